// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block holds the storage and the clocked control logic of a burst SRAM whose inputs are registered on the rising clock edge. An access opens when the chip is selected and one of two address strobes is low. The processor strobe opens an access whose write decision comes one cycle later. The controller strobe opens an access that decides between read and write in the same cycle. Once an access is open, the low two address bits can step through a four-word burst in either linear or interleaved order.

The word is 18 bits wide: two 8-bit bytes, each with its own parity bit. Writes go to all lanes when the global write control is asserted, or to the selected lanes under the byte write enable. The shared data bus appears as a split input, output and output enable. The enable is raised only for a read while the asynchronous output enable is low. It is forced low as soon as a write is detected.

Top module: `sbsram_ctl`

## Requirements
- R1: After reset no access is open and `dq_oe_o` is low, even with `out_en_ni` low.
- R2: An access starts on a clock edge when `sel_a_ni`=0, `sel_b_i`=1, `sel_c_ni`=0 and an effective strobe is low. An effective strobe with any select inactive closes the open access. After that, write controls and step cycles change no stored word.
- R3: The processor strobe is ignored while `sel_a_ni` is high. An open access then continues unchanged.
- R4: The controller strobe is ignored while the processor strobe is effective. With both low, the access is a processor access and no write takes place at that edge.
- R5: A processor-strobe start ignores the write controls at its edge. If the write controls indicate a write at the next edge, `dq_i` is written to the loaded address.
- R6: A controller-strobe start samples the write controls at its own edge. It writes `dq_i` to `addr_i` when they indicate a write and is otherwise a read.
- R7: `all_wr_ni`=0 writes both lanes. Otherwise `byte_wr_ni`=0 writes each lane whose `lane_sel_ni` bit is 0. Lane 0 is `dq[7:0]` with parity `dq[16]`; lane 1 is `dq[15:8]` with parity `dq[17]`. With both controls high, nothing is written.
- R8: During an open read access, `dq_oe_o` follows `out_en_ni` inverted without a clock, and `dq_o` carries the stored word at the current burst address.
- R9: `dq_oe_o` is low during any cycle of an open access in which the write controls indicate a write. It stays low after a write has been performed in the access, until a new read starts, whatever `out_en_ni` is.
- R10: On a non-start cycle of an open access, `burst_step_ni`=0 advances the low two address bits after any write in that cycle. The upper bits hold, and the count wraps after four words.
- R11: `lin_order_i` is captured at the start edge. When 1, step k addresses (start+k) mod 4; when 0, it addresses start XOR k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| proc_strb_ni | input | 1 | Processor address strobe, active low |
| ctrl_strb_ni | input | 1 | Controller address strobe, active low |
| burst_step_ni | input | 1 | Burst advance, active low |
| sel_a_ni | input | 1 | Chip select A, active low |
| sel_b_i | input | 1 | Chip select B, active high |
| sel_c_ni | input | 1 | Chip select C, active low |
| all_wr_ni | input | 1 | Global write, active low |
| byte_wr_ni | input | 1 | Byte write enable, active low |
| lane_sel_ni | input | 2 | Per-lane byte selects, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| lin_order_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| dq_i | input | 18 | Write data bus |
| dq_o | output | 18 | Read data bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
A wrong burst offset or a wrong captured order shows at the ports as a wrong `dq_o` word on the first read cycle after the faulty step. A lost access flag shows as `dq_oe_o` dropping on the next read cycle. A wrongly set write-mode flag keeps the bus silent during reads that should drive it. A lane-enable error writes nothing visible at first and surfaces only when that word is read back, so the bench reads after every kind of write. Its random phase re-reads each address many times.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  parameter int unsigned BYTE_W  = 8;
  parameter int unsigned LANES   = 2;
  parameter int unsigned BURST_W = 2;
  localparam int unsigned DATA_W = BYTE_W * LANES;
  localparam int unsigned WORD_W = DATA_W + LANES;
endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] start_i,
  input  logic          linear_i,
  input  logic          step_i,
  output logic [CW-1:0] addr_o
);
  logic [CW-1:0] start_q, k_q;
  logic          lin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      k_q     <= '0;
      lin_q   <= 1'b0;
    end else if (load_i) begin
      start_q <= start_i;
      k_q     <= '0;
      lin_q   <= linear_i;
    end else if (step_i) begin
      k_q <= k_q + 1'b1;
    end
  end

  assign addr_o = lin_q ? start_q + k_q : start_q ^ k_q;

  assert_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(start_i)) else $error("burst load");
  assert_lin_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && lin_q) |=> addr_o == CW'($past(addr_o) + 1'b1))
    else $error("linear step");
  assert_ilv_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !lin_q) |=> (addr_o ^ start_q) == CW'($past(addr_o ^ start_q) + 1'b1))
    else $error("interleaved step");
endmodule

// File: rtl/sbsram_lane.sv
module sbsram_lane #(
  parameter int unsigned AW = 8,
  parameter int unsigned W  = 9
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sbsram_ctl.sv
module sbsram_ctl
  import sbsram_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              proc_strb_ni,
  input  logic              ctrl_strb_ni,
  input  logic              burst_step_ni,
  input  logic              sel_a_ni,
  input  logic              sel_b_i,
  input  logic              sel_c_ni,
  input  logic              all_wr_ni,
  input  logic              byte_wr_ni,
  input  logic [LANES-1:0]  lane_sel_ni,
  input  logic              out_en_ni,
  input  logic              lin_order_i,
  input  logic [WORD_W-1:0] dq_i,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_oe_o
);
  localparam int unsigned HI_W = AW - BURST_W;

  logic             sel_all, proc_act, ctrl_act, strobe;
  logic             start_p, start_c, start, desel, cont;
  logic [LANES-1:0] wr_lanes, lane_we;
  logic             wr_req, mem_we;
  logic             active_q, wmode_q;
  logic [HI_W-1:0]  base_q;
  logic [BURST_W-1:0] low_addr;
  logic [AW-1:0]    cur_addr, mem_addr;

  assign sel_all  = !sel_a_ni && sel_b_i && !sel_c_ni;
  assign proc_act = !proc_strb_ni && !sel_a_ni;
  assign ctrl_act = !ctrl_strb_ni && !proc_act;
  assign strobe   = proc_act || ctrl_act;
  assign start_p  = proc_act && sel_all;
  assign start_c  = ctrl_act && sel_all;
  assign start    = start_p || start_c;
  assign desel    = strobe && !sel_all;
  assign cont     = active_q && !strobe;

  assign wr_lanes = !all_wr_ni ? '1 : (!byte_wr_ni ? ~lane_sel_ni : '0);
  assign wr_req   = |wr_lanes;
  assign mem_we   = (start_c || cont) && wr_req;
  assign lane_we  = mem_we ? wr_lanes : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wmode_q  <= 1'b0;
      base_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      wmode_q  <= start_c && wr_req;
      base_q   <= addr_i[AW-1:BURST_W];
    end else if (desel) begin
      active_q <= 1'b0;
    end else if (cont && wr_req) begin
      wmode_q  <= 1'b1;
    end
  end

  sbsram_burst #(.CW(BURST_W)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .start_i  (addr_i[BURST_W-1:0]),
    .linear_i (lin_order_i),
    .step_i   (cont && !burst_step_ni),
    .addr_o   (low_addr)
  );

  assign cur_addr = {base_q, low_addr};
  assign mem_addr = start_c ? addr_i : cur_addr;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W:0] rd;
    sbsram_lane #(.AW(AW), .W(BYTE_W + 1)) u_lane (
      .clk_i   (clk_i),
      .we_i    (lane_we[l]),
      .waddr_i (mem_addr),
      .wdata_i ({dq_i[DATA_W + l], dq_i[l*BYTE_W +: BYTE_W]}),
      .raddr_i (cur_addr),
      .rdata_o (rd)
    );
    assign dq_o[l*BYTE_W +: BYTE_W] = rd[BYTE_W-1:0];
    assign dq_o[DATA_W + l]         = rd[BYTE_W];
  end

  // bus is released whenever a write is in flight or was done in this access
  assign dq_oe_o = active_q && !wmode_q && !out_en_ni && !(cont && wr_req);

  assert_oe_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !out_en_ni) else $error("bus driven without output enable");
  assert_wr_tristate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !strobe && wr_req) |-> !dq_oe_o) else $error("bus driven during write");
  assert_proc_nowr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p |-> lane_we == '0) else $error("write on processor start");
  assert_sel_a_ignore_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strb_ni && sel_a_ni && ctrl_strb_ni) |=>
      (active_q == $past(active_q) && base_q == $past(base_q)))
    else $error("processor strobe not ignored");
  assert_gw_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && !all_wr_ni) |-> lane_we == '1) else $error("global write lanes");
  assert_desel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !sel_all) |=> !dq_oe_o) else $error("bus driven after deselect");
endmodule

// File: tb/sbsram_ctl_tb.sv
`timescale 1ns/1ps
module sbsram_ctl_tb;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic p_n = 1'b1, c_n = 1'b1, st_n = 1'b1;
  logic sa_n = 1'b1, sb = 1'b0, sc_n = 1'b1;
  logic aw_n = 1'b1, bw_n = 1'b1;
  logic [1:0] ls_n = 2'b11;
  logic oe_n = 1'b0, lin = 1'b1;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic dq_oe;

  int total = 0, bad = 0;
  bit done = 0;

  logic [17:0] ref_mem [DEPTH];
  logic m_act = 0, m_wm = 0, m_lin = 0;
  logic [AW-3:0] m_base = '0;
  logic [1:0] m_st = '0, m_k = '0;

  always #2 clk = ~clk;

  sbsram_ctl #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .proc_strb_ni(p_n), .ctrl_strb_ni(c_n), .burst_step_ni(st_n),
    .sel_a_ni(sa_n), .sel_b_i(sb), .sel_c_ni(sc_n),
    .all_wr_ni(aw_n), .byte_wr_ni(bw_n), .lane_sel_ni(ls_n),
    .out_en_ni(oe_n), .lin_order_i(lin),
    .dq_i(din), .dq_o(dout), .dq_oe_o(dq_oe)
  );

  function automatic logic [1:0] wr_lanes_f();
    if (!aw_n) return 2'b11;
    if (!bw_n) return ~ls_n;
    return 2'b00;
  endfunction

  function automatic logic [AW-1:0] cur_f();
    logic [1:0] lo;
    lo = m_lin ? m_st + m_k : m_st ^ m_k;
    return {m_base, lo};
  endfunction

  function automatic logic [17:0] merge(input logic [17:0] old, input logic [17:0] d,
                                        input logic [1:0] wl);
    logic [17:0] r;
    r = old;
    for (int l = 0; l < 2; l++)
      if (wl[l]) begin
        r[l*8 +: 8] = d[l*8 +: 8];
        r[16 + l]   = d[16 + l];
      end
    return r;
  endfunction

  // reference model, evaluated at each rising edge with the held inputs
  task automatic model_step();
    logic sel, pa, ca, strobe, cont;
    logic [1:0] wl;
    sel = !sa_n && sb && !sc_n;
    pa = !p_n && !sa_n;
    ca = !c_n && !pa;
    strobe = pa || ca;
    wl = wr_lanes_f();
    cont = m_act && !strobe;
    if (ca && sel && (wl != 0)) ref_mem[addr] = merge(ref_mem[addr], din, wl);
    if (cont && (wl != 0)) ref_mem[cur_f()] = merge(ref_mem[cur_f()], din, wl);
    if (strobe && sel) begin
      m_act = 1; m_wm = ca && (wl != 0);
      m_base = addr[AW-1:2]; m_st = addr[1:0]; m_k = 0; m_lin = lin;
    end else if (strobe) m_act = 0;
    else if (cont) begin
      if (wl != 0) m_wm = 1;
      if (!st_n) m_k = m_k + 1'b1;
    end
  endtask

  task automatic cyc(input logic ip, ic, isa, isb, isc, iaw, ibw, input logic [1:0] ils,
                     input logic ist, input logic [AW-1:0] ia, input logic [17:0] id,
                     input logic ioe, input logic ilin);
    @(negedge clk);
    p_n = ip; c_n = ic; sa_n = isa; sb = isb; sc_n = isc;
    aw_n = iaw; bw_n = ibw; ls_n = ils; st_n = ist;
    addr = ia; din = id; oe_n = ioe; lin = ilin;
    @(posedge clk);
    model_step();
    #1;
  endtask

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bus(input string tag);
    logic strobe, wr_now, exp_oe;
    strobe = (!p_n && !sa_n) || !c_n;
    wr_now = m_act && !strobe && (wr_lanes_f() != 0);
    exp_oe = m_act && !m_wm && !oe_n && !wr_now;
    chk({tag, " oe"}, {17'd0, dq_oe}, {17'd0, exp_oe});
    if (exp_oe) chk({tag, " data"}, dout, ref_mem[cur_f()]);
  endtask

  // shorthands: proc start, ctrl start, continuation
  task automatic p_start(input logic [AW-1:0] a, input logic ilin);
    cyc(0, 1, 0, 1, 0, $urandom_range(1), $urandom_range(1), 2'($urandom), 1, a, 18'($urandom), 0, ilin);
  endtask
  task automatic c_start(input logic [AW-1:0] a, input logic iaw, ibw, input logic [1:0] ils,
                         input logic [17:0] d);
    cyc(1, 0, 0, 1, 0, iaw, ibw, ils, 1, a, d, 0, 1);
  endtask
  task automatic cont_c(input logic ist, iaw, ibw, input logic [1:0] ils, input logic [17:0] d);
    cyc(1, 1, 0, 1, 0, iaw, ibw, ils, ist, '0, d, 0, 1);
  endtask

  initial begin
    logic [17:0] old, d;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset oe", {17'd0, dq_oe}, 18'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 idle oe", {17'd0, dq_oe}, 18'd0);

    for (int a = 0; a < DEPTH; a++) c_start(AW'(a), 0, 1, 2'b11, 18'($urandom));
    chk_bus("R9 after ctrl write");

    // R8: read and asynchronous output enable
    p_start(8'h12, 1);
    chk_bus("R8 proc read");
    #1 oe_n = 1'b1; #0.5;
    chk("R8 oe high releases", {17'd0, dq_oe}, 18'd0);
    #0.2 oe_n = 1'b0; #0.3;
    chk("R8 oe low drives", dout, ref_mem[8'h12]);

    // R3: processor strobe with sel A high leaves the open access alone
    cyc(0, 1, 1, 1, 0, 1, 1, 2'b11, 1, 8'h99, '0, 0, 1);
    chk("R3 access kept", dout, ref_mem[8'h12]);
    chk_bus("R3 bus");

    // R4: both strobes low with global write: no write, read access
    old = ref_mem[8'h40];
    cyc(0, 0, 0, 1, 0, 0, 1, 2'b11, 1, 8'h40, ~old, 0, 1);
    chk("R4 no write, read data", dout, old);
    chk("R4 oe", {17'd0, dq_oe}, 18'd1);

    // R5 + R7: proc start, then byte write of lane 0 at next edge
    old = ref_mem[8'h55];
    p_start(8'h55, 1);
    d = 18'($urandom);
    cont_c(1, 1, 0, 2'b10, d);
    chk_bus("R9 tri-state during write");
    p_start(8'h55, 1);
    chk("R7 lane0 write", dout, {old[17], d[16], old[15:8], d[7:0]});
    chk("R5 write landed", dout, ref_mem[8'h55]);

    // R7: lane 1 via ctrl strobe, then no-write controls leave word intact
    old = ref_mem[8'h66];
    d = 18'($urandom);
    c_start(8'h66, 1, 0, 2'b01, d);
    c_start(8'h66, 1, 1, 2'b00, ~d);
    chk("R7 lane1 write, R6 read", dout, {d[17], old[16], d[15:8], old[7:0]});
    chk("R6 ctrl read oe", {17'd0, dq_oe}, 18'd1);

    // R2: deselect closes the access; following write controls do nothing
    old = ref_mem[8'h66];
    cyc(1, 0, 0, 0, 0, 1, 1, 2'b11, 1, 8'h66, '0, 0, 1);
    chk("R2 deselect oe", {17'd0, dq_oe}, 18'd0);
    cont_c(0, 0, 1, 2'b11, ~old);
    cyc(0, 1, 0, 1, 1, 1, 1, 2'b11, 1, 8'h66, '0, 0, 1);
    chk("R2 no start with sel C high", {17'd0, dq_oe}, 18'd0);
    p_start(8'h66, 1);
    chk("R2 word unchanged", dout, old);

    // R10/R11: bursts in both orders
    p_start(8'h21, 1);
    for (int k = 1; k < 5; k++) begin
      cont_c(0, 1, 1, 2'b11, '0);
      chk("R11 linear burst", dout, ref_mem[{6'h08, 2'(1 + k)}]);
    end
    p_start(8'h22, 0);
    for (int k = 1; k < 5; k++) begin
      cont_c(0, 1, 1, 2'b11, '0);
      chk("R11 interleaved burst", dout, ref_mem[{6'h08, 2'(2) ^ 2'(k)}]);
    end
    cont_c(1, 1, 1, 2'b11, '0);
    chk("R10 hold without step", dout, ref_mem[{6'h08, 2'(2) ^ 2'(4)}]);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom_range(9);
      case (op)
        0, 1: p_start(AW'($urandom), 1'($urandom));
        2, 3: c_start(AW'($urandom), $urandom_range(3) != 0, 1'($urandom), 2'($urandom), 18'($urandom));
        4:    cyc(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  $urandom_range(3) != 0, 1'($urandom), 2'($urandom), 1'($urandom),
                  AW'($urandom), 18'($urandom), 1'($urandom), 1'($urandom));
        default: cyc(1, 1, 1'($urandom), 1'($urandom), 1'($urandom),
                     $urandom_range(3) != 0, $urandom_range(2) != 0, 2'($urandom), 1'($urandom),
                     AW'($urandom), 18'($urandom), $urandom_range(4) == 0, 1'($urandom));
      endcase
      chk_bus("R8/R9/R10 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule